// File: doc/BRIEF.md
# Frequency-Locked Loop Digital Core

This block closes a frequency-locked loop around a tapped oscillator. A slow reference strobe and a strobe from the controlled oscillator both arrive as one-cycle pulses in the block clock domain. The oscillator strobe passes through a power-of-two pre-divider and then a divide-by-(N+1) stage. The result is weighed against the reference in a 10-bit saturating up/down integrator, which rises on reference pulses and falls on divided-oscillator pulses. When the loop settles, the oscillator runs at D·(N+1) times the reference.

The integrator's upper five bits pick a coarse oscillator tap, which is clamped to a highest usable tap of 28. Its lower five bits set a fraction. Within every 32-cycle frame the modulator asks for the next-higher tap on exactly that many cycles, spread out as evenly as it can. The tap and the fraction are captured once per frame, so the two outputs always describe the same frame. A disable input holds the select at the base tap.

The modulator is a two-state machine. `MOD_INIT` is entered from reset and lasts one cycle, during which it captures the first tap and fraction. It then always moves to `MOD_RUN`. `MOD_RUN` steps a frame counter and a fraction accumulator, and stays in `MOD_RUN`. On the frame's last cycle it recaptures the tap and fraction and clears the accumulator.

Top module: `fll_core`

## Requirements
- R1: After reset, `integ` is 0, `tap` is 0 and `tap_sel` is 0.
- R2: A `ref_tick` pulse with no coincident feedback pulse raises `integ` by one on the next clock edge.
- R3: Feedback pulses occur once per D·(N+1) `osc_tick` pulses. D is selected by `div_sel` as follows: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8. N is `mult_n`. The feedback pulse is registered one cycle after the qualifying `osc_tick`. It lowers `integ` by one on the edge after that.
- R4: If a reference pulse and a feedback pulse land on the same cycle, `integ` is unchanged.
- R5: `integ` saturates: it stays at 1023 under further reference pulses and at 0 under further feedback pulses.
- R6: `tap` equals `integ[9:5]`, clamped to a maximum of 28. It is refreshed at each 32-cycle frame boundary, so it is valid no more than 33 cycles after `integ` settles.
- R7: In every 32-cycle frame, `tap_sel` is 1 on exactly `integ[4:0]` cycles (the value captured at the frame start).
- R8: Select cycles are spread evenly: for a fraction of 16 or less, `tap_sel` is never high on two consecutive cycles.
- R9: While `mod_off` is 1, `tap_sel` is 0 on every cycle.
- R10: While `tap` is 28, `tap_sel` is 0, since no higher tap exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle reference strobe |
| osc_tick | input | 1 | One-cycle strobe from the controlled oscillator |
| mult_n | input | 7 | Multiplier N; the loop divides by N+1 |
| div_sel | input | 2 | Pre-divider select: 0 gives /1, 1 gives /2, 2 gives /4, 3 gives /8 |
| mod_off | input | 1 | 1 forces the base tap on every cycle |
| tap | output | 5 | Coarse tap index for the current frame |
| tap_sel | output | 1 | 1 selects tap+1 on this cycle, 0 selects the base tap |
| integ | output | 10 | Frequency integrator value |

## Verification
The bench drives the integrator to a series of values that separate the tap path from the fraction path:
- a zero fraction;
- a half fraction (16), which exposes grouped versus interleaved select cycles;
- the full fraction (31);
- a mid-range tap;
- values at and beyond the clamped tap 28, which must suppress the select.

For each value it counts select cycles over two full frames.

Separate sequences apply the following:
- coincident reference and feedback pulses;
- runs of pulses past both integrator limits;
- oscillator pulse trains under two divider settings, which tell the pre-divider apart from the N+1 stage by checking the pulse before and the pulse at the threshold.

// File: rtl/fll_pkg.sv
package fll_pkg;
    typedef enum logic {
        MOD_INIT,
        MOD_RUN
    } mod_state_e;
endpackage

// File: rtl/fll_fb_divider.sv
module fll_fb_divider #(
    parameter int N_W    = 7,
    parameter int DSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic [N_W-1:0]    mult_n,
    input  logic [DSEL_W-1:0] div_sel,
    output logic              fb_tick
);
    localparam int PRE_W = (2 ** DSEL_W) - 1;

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] pre_last;
    logic [N_W-1:0]   post_cnt;
    logic             pre_pulse;

    always_comb begin
        pre_last = '0;
        for (int i = 0; i < PRE_W; i++) begin
            if (i < 32'(div_sel)) pre_last[i] = 1'b1;
        end
    end

    assign pre_pulse = osc_tick && (pre_cnt >= pre_last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt  <= '0;
            post_cnt <= '0;
            fb_tick  <= 1'b0;
        end else begin
            fb_tick <= 1'b0;
            if (pre_pulse) begin
                pre_cnt <= '0;
                if (post_cnt >= mult_n) begin
                    post_cnt <= '0;
                    fb_tick  <= 1'b1;
                end else begin
                    post_cnt <= post_cnt + 1'b1;
                end
            end else if (osc_tick) begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end

    // R3: a feedback pulse always follows an oscillator pulse
    assert_fb_from_osc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fb_tick |-> $past(osc_tick));
endmodule

// File: rtl/fll_integrator.sv
module fll_integrator #(
    parameter int INT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_tick,
    input  logic             down_tick,
    output logic [INT_W-1:0] value
);
    localparam logic [INT_W-1:0] TOP = {INT_W{1'b1}};

    logic go_up;
    logic go_down;

    assign go_up   = up_tick && !down_tick;
    assign go_down = down_tick && !up_tick;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (go_up && value != TOP) begin
            value <= value + 1'b1;
        end else if (go_down && value != '0) begin
            value <= value - 1'b1;
        end
    end

    assert_inc_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (up_tick && !down_tick && value != TOP) |=> value == $past(value) + 1'b1);
    assert_cancel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (up_tick == down_tick) |=> $stable(value));
    assert_sat_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (value == TOP && up_tick && !down_tick) |=> value == TOP);
    assert_sat_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (value == '0 && down_tick && !up_tick) |=> value == '0);
endmodule

// File: rtl/fll_modulator.sv
module fll_modulator
    import fll_pkg::*;
#(
    parameter int TAP_W   = 5,
    parameter int MOD_W   = 5,
    parameter int TAP_MAX = 28
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [TAP_W+MOD_W-1:0] integ,
    input  logic                   mod_off,
    output logic [TAP_W-1:0]       tap,
    output logic                   tap_sel
);
    localparam logic [MOD_W-1:0] FRAME_LAST = {MOD_W{1'b1}};
    localparam logic [TAP_W-1:0] TOP_TAP    = TAP_W'(TAP_MAX);

    mod_state_e       state, state_nx;
    logic [MOD_W-1:0] frame_cnt;
    logic [MOD_W-1:0] acc_q;
    logic [MOD_W-1:0] frac_q;
    logic [TAP_W-1:0] tap_q;
    logic [TAP_W-1:0] coarse;
    logic [TAP_W-1:0] tap_nx;
    logic [MOD_W:0]   sum;
    logic             carry;
    logic             reload;

    assign coarse = integ[TAP_W+MOD_W-1:MOD_W];
    assign tap_nx = (coarse > TOP_TAP) ? TOP_TAP : coarse;
    assign sum    = {1'b0, acc_q} + {1'b0, frac_q};
    assign carry  = sum[MOD_W];
    assign reload = (state == MOD_INIT) || (frame_cnt == FRAME_LAST);

    always_comb begin
        state_nx = state;
        unique case (state)
            MOD_INIT: state_nx = MOD_RUN;
            MOD_RUN:  state_nx = MOD_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= MOD_INIT;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_cnt <= '0;
            acc_q     <= '0;
            frac_q    <= '0;
            tap_q     <= '0;
        end else begin
            frame_cnt <= (state == MOD_INIT) ? '0 : frame_cnt + 1'b1;
            acc_q     <= reload ? '0 : sum[MOD_W-1:0];
            if (reload) begin
                tap_q  <= tap_nx;
                frac_q <= integ[MOD_W-1:0];
            end
        end
    end

    assign tap     = tap_q;
    assign tap_sel = (state == MOD_RUN) && carry && !mod_off && (tap_q != TOP_TAP);

    // Frame tally kept for the R7 property
    logic [MOD_W:0] ones_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   ones_cnt <= '0;
        else if (state == MOD_INIT)   ones_cnt <= '0;
        else if (frame_cnt == FRAME_LAST) ones_cnt <= '0;
        else                          ones_cnt <= ones_cnt + {{MOD_W{1'b0}}, carry};
    end

    assert_tap_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tap <= TOP_TAP);
    assert_frame_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MOD_RUN && frame_cnt == FRAME_LAST)
            |-> (ones_cnt + {{MOD_W{1'b0}}, carry}) == {1'b0, frac_q});
    assert_spread_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MOD_RUN && frac_q <= MOD_W'(2 ** (MOD_W - 1)) && carry
            && frame_cnt != FRAME_LAST) |=> !carry);
endmodule

// File: rtl/fll_core.sv
module fll_core #(
    parameter int N_W     = 7,
    parameter int DSEL_W  = 2,
    parameter int INT_W   = 10,
    parameter int MOD_W   = 5,
    parameter int TAP_MAX = 28
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ref_tick,
    input  logic                     osc_tick,
    input  logic [N_W-1:0]           mult_n,
    input  logic [DSEL_W-1:0]        div_sel,
    input  logic                     mod_off,
    output logic [INT_W-MOD_W-1:0]   tap,
    output logic                     tap_sel,
    output logic [INT_W-1:0]         integ
);
    localparam int TAP_W = INT_W - MOD_W;

    logic fb_tick;

    fll_fb_divider #(.N_W(N_W), .DSEL_W(DSEL_W)) i_div (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
        .mult_n(mult_n), .div_sel(div_sel), .fb_tick(fb_tick)
    );

    fll_integrator #(.INT_W(INT_W)) i_int (
        .clk(clk), .rst_n(rst_n), .up_tick(ref_tick),
        .down_tick(fb_tick), .value(integ)
    );

    fll_modulator #(.TAP_W(TAP_W), .MOD_W(MOD_W), .TAP_MAX(TAP_MAX)) i_mod (
        .clk(clk), .rst_n(rst_n), .integ(integ), .mod_off(mod_off),
        .tap(tap), .tap_sel(tap_sel)
    );

    assert_mod_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mod_off |-> !tap_sel);
    assert_top_tap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tap == TAP_W'(TAP_MAX)) |-> !tap_sel);
endmodule

// File: tb/test_fll_core.sv
module test_fll_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic       osc_tick = 1'b0;
    logic [6:0] mult_n = '0;
    logic [1:0] div_sel = '0;
    logic       mod_off = 1'b0;
    logic [4:0] tap;
    logic       tap_sel;
    logic [9:0] integ;

    int tests = 0;
    int fails = 0;
    int integ_exp = 0;
    bit done = 0;

    always #10 clk = ~clk;

    fll_core i_fll_core (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .osc_tick(osc_tick),
        .mult_n(mult_n), .div_sel(div_sel), .mod_off(mod_off),
        .tap(tap), .tap_sel(tap_sel), .integ(integ)
    );

    // {target, mod_off, expected tap, expected selects per frame}
    localparam int NV = 9;
    localparam logic [21:0] VEC [NV] = '{
        {10'd0,    1'b0, 5'd0,  6'd0},
        {10'd16,   1'b0, 5'd0,  6'd16},
        {10'd37,   1'b0, 5'd1,  6'd5},
        {10'd37,   1'b1, 5'd1,  6'd0},
        {10'd31,   1'b0, 5'd0,  6'd31},
        {10'd500,  1'b0, 5'd15, 6'd20},
        {10'd880,  1'b0, 5'd27, 6'd16},
        {10'd900,  1'b0, 5'd28, 6'd0},
        {10'd1023, 1'b0, 5'd28, 6'd0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ref_pulse();
        @(negedge clk) ref_tick = 1'b1;
        @(negedge clk) ref_tick = 1'b0;
    endtask

    task automatic osc_pulse();
        @(negedge clk) osc_tick = 1'b1;
        @(negedge clk) osc_tick = 1'b0;
        @(negedge clk);
    endtask

    task automatic move_to(input int target);
        while (integ_exp != target) begin
            if (integ_exp < target) begin
                ref_pulse();
                integ_exp++;
            end else begin
                osc_pulse();
                integ_exp--;
            end
        end
        @(negedge clk);
    endtask

    task automatic count_sel(output int ones, output int maxrun);
        int run = 0;
        ones = 0;
        maxrun = 0;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            if (tap_sel) begin
                ones++;
                run++;
                if (run > maxrun) maxrun = run;
            end else begin
                run = 0;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int ones;
        int maxrun;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(integ == 0, "R1 integ", int'(integ), 0);
        check(tap == 0, "R1 tap", int'(tap), 0);
        check(tap_sel == 0, "R1 tap_sel", int'(tap_sel), 0);

        // Table walk: R2/R3 movement, R6 tap, R7 count, R8 spread, R9, R10
        for (int v = 0; v < NV; v++) begin
            move_to(int'(VEC[v][21:12]));
            mod_off = VEC[v][11];
            check(int'(integ) == integ_exp, "R2/R3 integ", int'(integ), integ_exp);
            repeat (40) @(negedge clk);
            check(tap == VEC[v][10:6], "R6 tap", int'(tap), int'(VEC[v][10:6]));
            count_sel(ones, maxrun);
            check(ones == 2 * int'(VEC[v][5:0]), "R7/R9/R10 select count",
                  ones, 2 * int'(VEC[v][5:0]));
            if (ones > 0 && ones <= 32)
                check(maxrun <= 1, "R8 spread", maxrun, 1);
            mod_off = 1'b0;
        end

        // R5 upper saturation
        repeat (3) ref_pulse();
        @(negedge clk);
        check(integ == 10'd1023, "R5 top", int'(integ), 1023);

        // R4 cancellation
        move_to(500);
        @(negedge clk) osc_tick = 1'b1;
        @(negedge clk) begin osc_tick = 1'b0; ref_tick = 1'b1; end
        @(negedge clk) ref_tick = 1'b0;
        repeat (3) @(negedge clk);
        check(integ == 10'd500, "R4 cancel", int'(integ), 500);

        // R3 divider: D=4 (div_sel=2), N=2 -> 12 pulses
        move_to(100);
        mult_n = 7'd2;
        div_sel = 2'd2;
        repeat (11) osc_pulse();
        check(integ == 10'd100, "R3 D4N2 before", int'(integ), 100);
        osc_pulse();
        check(integ == 10'd99, "R3 D4N2 at", int'(integ), 99);
        integ_exp = 99;
        // R3 divider: D=8 (div_sel=3), N=0 -> 8 pulses
        mult_n = 7'd0;
        div_sel = 2'd3;
        repeat (7) osc_pulse();
        check(integ == 10'd99, "R3 D8N0 before", int'(integ), 99);
        osc_pulse();
        check(integ == 10'd98, "R3 D8N0 at", int'(integ), 98);
        integ_exp = 98;
        div_sel = 2'd0;

        // R5 lower saturation
        move_to(0);
        repeat (3) osc_pulse();
        check(integ == 10'd0, "R5 bottom", int'(integ), 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule